// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, for every received Ethernet frame, whether the frame is kept or dropped, by looking only at the six destination address octets. The octets arrive one per clock with a qualifier. A start strobe marks the first of them, and idle cycles may occur between them. One clock after the sixth octet has been taken, the block raises a one-cycle decision strobe together with an accept flag.

The filter is configured with static inputs: the station address, four multicast prefix entries, a promiscuous switch and an accept-all-group switch. A frame is accepted if at least one of these is true:
- promiscuous mode is on;
- the destination is the broadcast address;
- the destination equals the station address;
- the group bit is set and accept-all-group is on;
- the first three destination octets equal an enabled multicast prefix entry.

Configuration must be held stable while a frame's address is arriving. It is sampled together with the sixth octet.

Top module: `eth_rx_dest_filter`

## Requirements
- R1: While and right after synchronous reset, `dec_valid` and `dec_accept` are 0. An octet that arrives without a preceding start strobe (`oct_sof`=1 with `oct_vld`=1) is ignored.
- R2: `dec_valid` is high for exactly one cycle, on the clock after the sixth destination octet is taken. Octets after the sixth, up to the next start strobe, produce no further decision.
- R3: A start strobe in the middle of an address discards the partial address. Its octet becomes octet 0 of a new address, and only the new address is decided.
- R4: The station address is `{stn_hi[15:0], stn_lo[31:0]}`, with octet 0 (first received) in `stn_hi[15:8]` and octet 5 in `stn_lo[7:0]`. A destination equal to it is accepted.
- R5: The destination FF:FF:FF:FF:FF:FF is accepted in every configuration.
- R6: With `promisc`=1, every destination is accepted.
- R7: With `all_group`=1, every destination whose octet 0 has bit 0 (the group bit) set is accepted.
- R8: Multicast entry k sits in `mc_prefix[32*k+31 : 32*k]`, with octet 0 in bits 23:16, octet 1 in bits 15:8 and octet 2 in bits 7:0. Bits 31:24 are ignored. An enabled entry that equals the first three destination octets accepts the frame, whatever octets 3 to 5 hold.
- R9: An entry whose bits 23:0 are all zero is disabled and matches nothing, including a destination that starts with 00:00:00.
- R10: A destination that none of the R4 to R9 rules accepts is rejected (`dec_accept`=0 with `dec_valid`=1). `dec_accept` is 0 whenever `dec_valid` is 0.
- R11: Cycles with `oct_vld`=0 between octets stall the capture. No decision is made during them, and the result is the same as for back-to-back octets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oct_vld | input | 1 | Destination octet qualifier |
| oct_sof | input | 1 | Marks the octet as octet 0 of a new address |
| oct_data | input | 8 | Destination octet |
| stn_hi | input | 16 | Station address octets 0 and 1 |
| stn_lo | input | 32 | Station address octets 2 to 5 |
| mc_prefix | input | 128 | Four 32-bit multicast prefix entries |
| promisc | input | 1 | Accept every frame |
| all_group | input | 1 | Accept every group-addressed frame |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Accept flag, meaningful with dec_valid |

## Verification
Two situations can occur in the same cycle: the sixth octet completing one address, and a start strobe or further octets beginning another. The bench sends truncated addresses that a fresh start strobe interrupts, and trailing octets right after a decision. It judges both by the count and timing of `dec_valid` pulses and by the accept value computed for the surviving address. Several accept rules can also be true at once, for example a broadcast address under promiscuous mode or a station address that also matches a prefix entry. Random configurations that draw destinations from the station address, the prefix entries and the broadcast address make these overlaps occur often. The bench then checks the OR of the rules against its own model.

// File: rtl/eaf_pkg.sv
package eaf_pkg;
  localparam int OCT_W     = 8;
  localparam int ADDR_OCTS = 6;
  localparam int PFX_OCTS  = 3;
  localparam int ADDR_W    = OCT_W * ADDR_OCTS;
  localparam int PFX_W     = OCT_W * PFX_OCTS;
  typedef logic [ADDR_W-1:0] mac_t;
  typedef logic [PFX_W-1:0]  pfx_t;
endpackage

// File: rtl/eaf_dest_capture.sv
module eaf_dest_capture
  import eaf_pkg::*;
#(
  parameter int N_OCT = ADDR_OCTS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oct_vld,
  input  logic             oct_sof,
  input  logic [OCT_W-1:0] oct_data,
  output logic [N_OCT*OCT_W-1:0] dest,
  output logic             last
);
  localparam int IDX_W = $clog2(N_OCT + 1);
  localparam logic [IDX_W-1:0] IDLE  = IDX_W'(N_OCT);
  localparam logic [IDX_W-1:0] FINAL = IDX_W'(N_OCT - 1);

  logic [IDX_W-1:0] idx;
  logic [OCT_W-1:0] held [N_OCT-1];

  // position counter: IDLE means "no address in progress"
  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= IDLE;
    end else if (oct_vld && oct_sof) begin
      idx <= IDX_W'(1);
    end else if (oct_vld && idx != IDLE) begin
      idx <= idx + IDX_W'(1);
    end
  end

  // octet store for all but the final octet
  always_ff @(posedge clk) begin
    for (int g = 0; g < N_OCT - 1; g++) begin
      if (oct_vld && ((oct_sof && g == 0) || (!oct_sof && idx == IDX_W'(g))))
        held[g] <= oct_data;
    end
  end

  assign last = oct_vld && !oct_sof && (idx == FINAL);

  generate
    for (genvar g = 0; g < N_OCT - 1; g++) begin : g_pack
      assign dest[(N_OCT-1-g)*OCT_W +: OCT_W] = held[g];
    end
  endgenerate
  assign dest[OCT_W-1:0] = oct_data;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx <= IDLE) else $error("index out of range"); // R2

  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (rst)
    (oct_vld && oct_sof) |=> (idx == IDX_W'(1))) else $error("sof restart"); // R3
endmodule

// File: rtl/eaf_station_match.sv
module eaf_station_match
  import eaf_pkg::*;
(
  input  mac_t        dest,
  input  logic [15:0] stn_hi,
  input  logic [31:0] stn_lo,
  output logic        ucast_hit,
  output logic        bcast_hit
);
  mac_t station;
  assign station   = {stn_hi, stn_lo};
  assign ucast_hit = (dest == station);
  assign bcast_hit = &dest;
endmodule

// File: rtl/eaf_prefix_match.sv
module eaf_prefix_match
  import eaf_pkg::*;
#(
  parameter int N_ENT   = 4,
  parameter int ENTRY_W = 32
) (
  input  logic [N_ENT*ENTRY_W-1:0] entries,
  input  pfx_t                     prefix,
  output logic                     hit
);
  logic [N_ENT-1:0] ent_hit;

  generate
    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
      pfx_t val;
      assign val        = entries[k*ENTRY_W +: PFX_W];
      assign ent_hit[k] = (|val) && (val == prefix);
    end
  endgenerate

  assign hit = |ent_hit;
endmodule

// File: rtl/eth_rx_dest_filter.sv
module eth_rx_dest_filter
  import eaf_pkg::*;
#(
  parameter int N_MCAST = 4,
  parameter int ENTRY_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       oct_vld,
  input  logic                       oct_sof,
  input  logic [7:0]                 oct_data,
  input  logic [15:0]                stn_hi,
  input  logic [31:0]                stn_lo,
  input  logic [N_MCAST*ENTRY_W-1:0] mc_prefix,
  input  logic                       promisc,
  input  logic                       all_group,
  output logic                       dec_valid,
  output logic                       dec_accept
);
  mac_t dest;
  logic last, ucast_hit, bcast_hit, pfx_hit, group_bit, take;

  eaf_dest_capture #(.N_OCT(ADDR_OCTS)) u_cap (
    .clk(clk), .rst(rst), .oct_vld(oct_vld), .oct_sof(oct_sof),
    .oct_data(oct_data), .dest(dest), .last(last)
  );

  eaf_station_match u_stn (
    .dest(dest), .stn_hi(stn_hi), .stn_lo(stn_lo),
    .ucast_hit(ucast_hit), .bcast_hit(bcast_hit)
  );

  eaf_prefix_match #(.N_ENT(N_MCAST), .ENTRY_W(ENTRY_W)) u_pfx (
    .entries(mc_prefix), .prefix(dest[ADDR_W-1 -: PFX_W]), .hit(pfx_hit)
  );

  assign group_bit = dest[ADDR_W-OCT_W];
  assign take = promisc | bcast_hit | ucast_hit | (all_group & group_bit) | pfx_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= last;
      dec_accept <= last & take;
    end
  end

  AST_VALID_FOLLOWS_OCTET: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(oct_vld)) else $error("decision without octet"); // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid) else $error("decision longer than a cycle"); // R2

  AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> dec_valid) else $error("accept without valid"); // R10

  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(promisc)) |-> dec_accept) else $error("promisc reject"); // R6
endmodule

// File: tb/eth_rx_dest_filter_tb.sv
module eth_rx_dest_filter_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         oct_vld, oct_sof;
  logic [7:0]   oct_data;
  logic [15:0]  stn_hi;
  logic [31:0]  stn_lo;
  logic [127:0] mc_prefix;
  logic         promisc, all_group;
  logic         dec_valid, dec_accept;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  eth_rx_dest_filter u_dut (
    .clk(clk), .rst(rst), .oct_vld(oct_vld), .oct_sof(oct_sof),
    .oct_data(oct_data), .stn_hi(stn_hi), .stn_lo(stn_lo),
    .mc_prefix(mc_prefix), .promisc(promisc), .all_group(all_group),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  function automatic bit model(input logic [47:0] d);
    bit r;
    r = promisc || (&d) || (d == {stn_hi, stn_lo}) || (all_group && d[40]);
    for (int k = 0; k < 4; k++) begin
      if (mc_prefix[32*k +: 24] != 24'h0 && mc_prefix[32*k +: 24] == d[47:24]) r = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_check(input string req);
    check(dec_valid == 1'b0, req, dec_valid, 0);
  endtask

  // sends six octets; optional gaps; checks decision timing and value
  task automatic send(input logic [47:0] d, input bit gaps, input string req);
    bit e;
    e = model(d);
    for (int i = 0; i < 6; i++) begin
      if (gaps && i > 0) begin
        @(negedge clk);
        oct_vld = 1'b0; oct_sof = 1'b0;
        idle_check("R11");
      end
      @(negedge clk);
      if (i > 0) idle_check("R2");
      oct_vld = 1'b1; oct_sof = (i == 0); oct_data = d[47 - 8*i -: 8];
    end
    @(negedge clk);
    oct_vld = 1'b0; oct_sof = 1'b0;
    check(dec_valid == 1'b1, {req, " valid"}, dec_valid, 1);
    check(dec_accept == e, {req, " accept"}, dec_accept, e);
    @(negedge clk);
    check(dec_valid == 1'b0 && dec_accept == 1'b0, "R2 pulse end R10", dec_valid, 0);
  endtask

  task automatic rand_cfg();
    stn_hi = 16'($urandom) & 16'hFEFF;
    stn_lo = $urandom;
    for (int k = 0; k < 4; k++)
      mc_prefix[32*k +: 32] = ($urandom % 4 == 0) ? {8'($urandom), 24'h0} : $urandom;
    promisc   = ($urandom % 6 == 0);
    all_group = ($urandom % 4 == 0);
  endtask

  function automatic logic [47:0] pick_dest();
    int s;
    logic [47:0] d;
    s = $urandom % 6;
    d = {$urandom, 16'($urandom)};
    case (s)
      0: d = {stn_hi, stn_lo};
      1: d = 48'hFFFF_FFFF_FFFF;
      2: d = {mc_prefix[32*($urandom % 4) +: 24], d[23:0]};
      3: d[40] = 1'b1;
      default: d[40] = 1'b0;
    endcase
    return d;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; oct_vld = 1'b0; oct_sof = 1'b0; oct_data = 8'h0;
    stn_hi = 16'h0212; stn_lo = 32'h3456_789A;
    mc_prefix = '0; promisc = 1'b0; all_group = 1'b0;
    repeat (3) @(negedge clk);
    check(dec_valid == 0 && dec_accept == 0, "R1 in reset", dec_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(dec_valid == 0 && dec_accept == 0, "R1 after reset", dec_valid, 0);

    // R1: octets with no start strobe are ignored
    for (int i = 0; i < 8; i++) begin
      oct_vld = 1'b1; oct_sof = 1'b0; oct_data = 8'hFF;
      @(negedge clk);
      idle_check("R1 no sof");
    end
    oct_vld = 1'b0;

    // R4 unicast, R10 near miss
    send(48'h0212_3456_789A, 1'b0, "R4");
    send(48'h0212_3456_789B, 1'b0, "R10");
    // R5 broadcast, with gaps (R11)
    send(48'hFFFF_FFFF_FFFF, 1'b1, "R5 R11");
    send(48'h0212_3456_789A, 1'b1, "R4 R11");
    // R7 group bit
    send(48'h0300_0000_0001, 1'b0, "R10 group off");
    all_group = 1'b1;
    send(48'h0300_0000_0001, 1'b0, "R7");
    send(48'h0200_0000_0001, 1'b0, "R7 no group bit");
    all_group = 1'b0;
    // R8 prefix with junk in bits 31:24, octets 3..5 arbitrary
    mc_prefix[64 +: 32] = 32'hA501_005E_;
    mc_prefix[64 +: 32] = 32'hA501_005E;
    send(48'h0100_5E12_3456, 1'b0, "R8 hit");
    send(48'h0100_5F12_3456, 1'b0, "R8 miss");
    // R9 zero entry disabled (upper bits set but 23:0 zero)
    mc_prefix[0 +: 32] = 32'h7700_0000;
    send(48'h0000_0011_2233, 1'b0, "R9");
    // R6 promisc
    promisc = 1'b1;
    send(48'h0000_0011_2233, 1'b0, "R6");
    promisc = 1'b0;

    // R3: partial address interrupted by a new start strobe
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      oct_vld = 1'b1; oct_sof = (i == 0); oct_data = 8'hFF;
      @(negedge clk);
      idle_check("R3 partial");
    end
    oct_vld = 1'b0;
    send(48'h0212_3456_7800, 1'b0, "R3 restart");

    // R2: trailing octets after the sixth give no decision
    send(48'h0212_3456_789A, 1'b0, "R2");
    for (int i = 0; i < 4; i++) begin
      oct_vld = 1'b1; oct_sof = 1'b0; oct_data = 8'hFF;
      @(negedge clk);
      idle_check("R2 trailing");
    end
    oct_vld = 1'b0;

    // random mix
    for (int n = 0; n < 400; n++) begin
      if (n % 16 == 0) rand_cfg();
      send(pick_dest(), ($urandom % 3 == 0), "R4-mix R5 R6 R7 R8 R9 R10");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule